// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and a calendar. Seven fields are held in packed BCD: seconds, minutes, hours (24-hour), day-of-week, date, month and a two-digit year. A strobe input marks each period of a 32.768 kHz reference. A prescaler counts these strobes and advances the time by one second once per full division. Carries ripple from seconds through to the year. The date rolls over at the true end of every month, including February in leap years, for the years 2000 through 2099.

Software loads any field through a single-field write port, and all fields can be read in parallel at any time. A write to the seconds field also restarts the prescaler, so the next second begins a full period after the write. The block also drives a square wave at one cycle per second, taken from the prescaler state.

Top module: `rtc_calendar_core`

## Requirements
- R1: After synchronous reset the fields read 00:00:00, day-of-week 01, date 01, month 01, year 00, and the square output is low.
- R2: Seconds advance exactly once per DIV reference strobes, on the strobe that completes the division. With the strobe held low and no write, every field holds its value.
- R3: Seconds and minutes count 00 to 59 in BCD. A field at 59 returns to 00 and carries one into the next field.
- R4: Hours count 00 to 23 in BCD. Hour 23 wrapping to 00 advances the date by one day.
- R5: Day-of-week counts 01 to 07. It steps on every day advance and wraps from 07 to 01.
- R6: Months 04, 06, 09 and 11 end after date 30. All other months except 02 end after 31. The day after the last date is 01 of the next month.
- R7: February ends after 29 when the BCD year is a multiple of four, with 00 counted as leap, and after 28 otherwise.
- R8: Month 12 rolls to 01 and increments the year. Year 99 rolls to 00.
- R9: A write with wr_sel (0 seconds, 1 minutes, 2 hours, 3 day-of-week, 4 date, 5 month, 6 year) places wr_data in that field, visible on the outputs one clock later.
- R10: A write to seconds clears the prescaler, so the next advance comes DIV strobes after the write.
- R11: When a write and a one-second advance fall in the same clock, the written field takes the written value. All other fields advance as the advance alone would make them, with carries taken from the pre-write values.
- R12: The square output is low while the prescaler count is below DIV/2 and high from DIV/2 to DIV-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | One-clock strobe per reference period (32.768 kHz) |
| wr_en | input | 1 | Field write request |
| wr_sel | input | 3 | Field selector for the write |
| wr_data | input | 8 | BCD value to write |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD, 24-hour |
| dow_o | output | 8 | Day-of-week, 01 to 07 |
| date_o | output | 8 | Date of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Two-digit year, BCD |
| sq1hz_o | output | 1 | One-second square wave |

## Verification
A software write and a one-second advance can land in the same clock. The bench provokes this by running the prescaler to its last count and then asserting the write together with the completing strobe. In one case a minute write meets a seconds carry. In another, a seconds write meets an advance that rolls the hour into the next day. The expected result comes from a bench model that first advances every field and then overrides the written one. After the seconds case, the bench also checks that a full division must pass before the next advance.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef enum logic [2:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_DOW   = 3'd3,
        FLD_DATE  = 3'd4,
        FLD_MONTH = 3'd5,
        FLD_YEAR  = 3'd6,
        FLD_NONE  = 3'd7
    } fld_e;

    typedef struct packed {
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } tod_t;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] dow;
    } cal_t;

    typedef struct packed {
        logic       en;
        fld_e       sel;
        logic [7:0] data;
    } fld_wr_t;

    localparam logic [7:0] BCD_ZERO   = 8'h00;
    localparam logic [7:0] BCD_ONE    = 8'h01;
    localparam logic [7:0] SEC_MAX    = 8'h59;
    localparam logic [7:0] HOUR_MAX   = 8'h23;
    localparam logic [7:0] DOW_MAX    = 8'h07;
    localparam logic [7:0] MONTH_MAX  = 8'h12;
    localparam logic [7:0] YEAR_MAX   = 8'h99;

    // increment a two-digit packed BCD value (no range wrap)
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    // 10*T + U is a multiple of 4 exactly when 2*T + U is
    function automatic logic is_leap(input logic [7:0] yr);
        logic [4:0] s;
        s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
        return (s[1:0] == 2'b00);
    endfunction

    function automatic logic [7:0] month_end(input logic [7:0] mon,
                                             input logic [7:0] yr);
        logic [7:0] d;
        case (mon)
            8'h02:                      d = is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
            default:                    d = 8'h31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_en,
    input  logic clear,
    output logic tick,
    output logic sq
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV / 2);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (ref_en) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
        end
    end

    assign tick = ref_en && (cnt_q == LAST);
    assign sq   = (cnt_q >= HALF);

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);                                       // R2
    AST_CLEAR_RESTART: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0) && !sq);                       // R10

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_cal_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  fld_wr_t wr,
    output tod_t    tod,
    output logic    day_carry
);
    tod_t tod_q, tod_d;
    logic sec_end, min_end, hour_end;

    assign sec_end  = (tod_q.sec  >= SEC_MAX);
    assign min_end  = (tod_q.min  >= SEC_MAX);
    assign hour_end = (tod_q.hour >= HOUR_MAX);

    always_comb begin
        tod_d = tod_q;
        if (tick) begin
            tod_d.sec = sec_end ? BCD_ZERO : bcd_inc(tod_q.sec);
            if (sec_end) begin
                tod_d.min = min_end ? BCD_ZERO : bcd_inc(tod_q.min);
                if (min_end)
                    tod_d.hour = hour_end ? BCD_ZERO : bcd_inc(tod_q.hour);
            end
        end
        if (wr.en) begin
            case (wr.sel)
                FLD_SEC:  tod_d.sec  = wr.data;
                FLD_MIN:  tod_d.min  = wr.data;
                FLD_HOUR: tod_d.hour = wr.data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tod_q <= '{hour: BCD_ZERO, min: BCD_ZERO, sec: BCD_ZERO};
        else     tod_q <= tod_d;
    end

    assign day_carry = tick && sec_end && min_end && hour_end;
    assign tod       = tod_q;

    AST_TOD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick && !wr.en |=> $stable(tod_q));                   // R2
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        tick && !wr.en && tod_q.sec == SEC_MAX |=> tod_q.sec == BCD_ZERO); // R3
    AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (rst)
        day_carry && !wr.en |=> tod_q == '0);                  // R4

endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
    import rtc_cal_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    day_carry,
    input  fld_wr_t wr,
    output cal_t    cal
);
    cal_t       cal_q, cal_d;
    logic [7:0] last_day;
    logic       month_done, year_done;

    assign last_day   = month_end(cal_q.month, cal_q.year);
    assign month_done = (cal_q.date >= last_day);
    assign year_done  = (cal_q.month >= MONTH_MAX);

    always_comb begin
        cal_d = cal_q;
        if (day_carry) begin
            cal_d.dow  = (cal_q.dow >= DOW_MAX) ? BCD_ONE : bcd_inc(cal_q.dow);
            cal_d.date = month_done ? BCD_ONE : bcd_inc(cal_q.date);
            if (month_done) begin
                cal_d.month = year_done ? BCD_ONE : bcd_inc(cal_q.month);
                if (year_done)
                    cal_d.year = (cal_q.year >= YEAR_MAX) ? BCD_ZERO
                                                         : bcd_inc(cal_q.year);
            end
        end
        if (wr.en) begin
            case (wr.sel)
                FLD_DOW:   cal_d.dow   = wr.data;
                FLD_DATE:  cal_d.date  = wr.data;
                FLD_MONTH: cal_d.month = wr.data;
                FLD_YEAR:  cal_d.year  = wr.data;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cal_q <= '{year: BCD_ZERO, month: BCD_ONE, date: BCD_ONE, dow: BCD_ONE};
        else     cal_q <= cal_d;
    end

    assign cal = cal_q;

    AST_DOW_WRAP: assert property (@(posedge clk) disable iff (rst)
        day_carry && !wr.en && cal_q.dow == DOW_MAX |=> cal_q.dow == BCD_ONE);  // R5
    AST_MONTH_ROLL: assert property (@(posedge clk) disable iff (rst)
        day_carry && !wr.en && month_done |=> cal_q.date == BCD_ONE);           // R6
    AST_LEAP_FEB: assert property (@(posedge clk) disable iff (rst)
        day_carry && !wr.en && cal_q.month == 8'h02 && cal_q.date == 8'h28
        && is_leap(cal_q.year) |=> cal_q.date == 8'h29);                        // R7
    AST_YEAR_ROLL: assert property (@(posedge clk) disable iff (rst)
        day_carry && !wr.en && month_done && cal_q.month == MONTH_MAX
        && cal_q.year == YEAR_MAX |=> cal_q.year == BCD_ZERO
        && cal_q.month == BCD_ONE);                                             // R8

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int DIV = 32768
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_en,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] dow_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic       sq1hz_o
);
    fld_wr_t wr;
    tod_t    tod;
    cal_t    cal;
    logic    tick, day_carry, pre_clear;

    assign wr.en   = wr_en;
    assign wr.sel  = fld_e'(wr_sel);
    assign wr.data = wr_data;

    assign pre_clear = wr_en && (fld_e'(wr_sel) == FLD_SEC);

    rtc_prescaler #(.DIV(DIV)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .ref_en (ref_en),
        .clear  (pre_clear),
        .tick   (tick),
        .sq     (sq1hz_o)
    );

    rtc_time_chain u_time (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .wr        (wr),
        .tod       (tod),
        .day_carry (day_carry)
    );

    rtc_date_chain u_date (
        .clk       (clk),
        .rst       (rst),
        .day_carry (day_carry),
        .wr        (wr),
        .cal       (cal)
    );

    assign sec_o   = tod.sec;
    assign min_o   = tod.min;
    assign hour_o  = tod.hour;
    assign dow_o   = cal.dow;
    assign date_o  = cal.date;
    assign month_o = cal.month;
    assign year_o  = cal.year;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_sel == 3'd2 |=> hour_o == $past(wr_data));  // R9
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_sel == 3'd1 && tick |=> min_o == $past(wr_data)); // R11

endmodule

// File: tb/rtc_calendar_core_test.sv
module rtc_calendar_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int BDIV       = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
    logic       sq1hz_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_calendar_core #(.DIV(BDIV)) uut (
        .clk(clk), .rst(rst), .ref_en(ref_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o), .sq1hz_o(sq1hz_o)
    );

    typedef struct {
        string      req;
        logic [56:0] exp;
    } item_t;
    item_t q[$];

    int nvec = 0;
    int nerr = 0;
    bit done = 0;

    // bench reference model, plain integers
    int ms, mm, mh, mdw, md, mmo, my, pc;

    function automatic logic [7:0] to_bcd(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int from_bcd(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int mlen(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [56:0] model_vec();
        return {pc >= BDIV/2, to_bcd(ms), to_bcd(mm), to_bcd(mh), to_bcd(mdw),
                to_bcd(md), to_bcd(mmo), to_bcd(my)};
    endfunction

    task automatic model_tick();
        ms++;
        if (ms == 60) begin
            ms = 0; mm++;
            if (mm == 60) begin
                mm = 0; mh++;
                if (mh == 24) begin
                    mh = 0;
                    mdw = (mdw == 7) ? 1 : mdw + 1;
                    md++;
                    if (md > mlen(mmo, my)) begin
                        md = 1; mmo++;
                        if (mmo == 13) begin
                            mmo = 1; my = (my + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    task automatic model_write(int sel, logic [7:0] v);
        case (sel)
            0: begin ms = from_bcd(v); pc = 0; end
            1: mm  = from_bcd(v);
            2: mh  = from_bcd(v);
            3: mdw = from_bcd(v);
            4: md  = from_bcd(v);
            5: mmo = from_bcd(v);
            6: my  = from_bcd(v);
            default: ;
        endcase
    endtask

    // driver side
    task automatic expect_now(string r);
        item_t it;
        it.req = r;
        it.exp = model_vec();
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    task automatic pulse(int n);
        for (int i = 0; i < n; i++) begin
            ref_en = 1'b1;
            @(posedge clk); #1;
            ref_en = 1'b0;
            pc++;
            if (pc == BDIV) begin pc = 0; model_tick(); end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    task automatic wr(int sel, logic [7:0] v);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = v;
        @(posedge clk); #1;
        wr_en = 1'b0;
        model_write(sel, v);
    endtask

    // write during the strobe that completes the division
    task automatic wr_tick(int sel, logic [7:0] v);
        pulse(BDIV - 1 - pc);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = v; ref_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; ref_en = 1'b0;
        pc = 0;
        model_tick();
        model_write(sel, v);
    endtask

    task automatic set_clock(logic [7:0] h, logic [7:0] m, logic [7:0] s);
        wr(2, h); wr(1, m); wr(0, s);
    endtask

    task automatic set_cal(logic [7:0] dw, logic [7:0] d, logic [7:0] mo, logic [7:0] y);
        wr(3, dw); wr(4, d); wr(5, mo); wr(6, y);
    endtask

    task automatic day_edge(logic [7:0] dw, logic [7:0] d, logic [7:0] mo,
                            logic [7:0] y, string r);
        set_cal(dw, d, mo, y);
        set_clock(8'h23, 8'h59, 8'h59);
        pulse(BDIV);
        expect_now(r);
    endtask

    // monitor side
    initial begin
        forever begin
            item_t it;
            logic [56:0] act;
            wait (q.size() > 0);
            @(negedge clk);
            it  = q.pop_front();
            act = {sq1hz_o, sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o};
            nvec++;
            if (act !== it.exp) begin
                nerr++;
                $display("FAIL %s actual %h expected %h", it.req, act, it.exp);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        ms = 0; mm = 0; mh = 0; mdw = 1; md = 1; mmo = 1; my = 0; pc = 0;
        idle(3);
        rst = 1'b0;
        expect_now("R1 reset state");

        // prescaler and square wave
        pulse(3);             expect_now("R12 square low first half");
        pulse(1);             expect_now("R12 square high second half");
        pulse(3);             expect_now("R2 no advance before division");
        pulse(1);             expect_now("R2 advance on last strobe");
        idle(25);             expect_now("R2 hold with strobe low");

        // writes and carries
        set_clock(8'h10, 8'h59, 8'h59);
        expect_now("R9 field writes");
        set_cal(8'h04, 8'h17, 8'h08, 8'h31);
        expect_now("R9 calendar writes");
        pulse(BDIV);          expect_now("R3 seconds and minutes carry");

        // prescaler restart on seconds write
        pulse(5);
        wr(0, 8'h30);
        pulse(BDIV - 1);      expect_now("R10 no advance before full period");
        pulse(1);             expect_now("R10 advance one period after write");

        // day, month, year edges
        day_edge(8'h07, 8'h28, 8'h02, 8'h23, "R4 R5 R7 non-leap Feb end");
        day_edge(8'h02, 8'h28, 8'h02, 8'h24, "R7 leap Feb 28 to 29");
        day_edge(8'h03, 8'h29, 8'h02, 8'h24, "R7 leap Feb 29 to Mar 1");
        day_edge(8'h05, 8'h28, 8'h02, 8'h00, "R7 year 00 is leap");
        day_edge(8'h01, 8'h30, 8'h04, 8'h10, "R6 April end");
        day_edge(8'h01, 8'h30, 8'h11, 8'h10, "R6 November end");
        day_edge(8'h01, 8'h30, 8'h08, 8'h10, "R6 August 30 to 31");
        day_edge(8'h06, 8'h31, 8'h01, 8'h10, "R6 January end");
        day_edge(8'h07, 8'h31, 8'h12, 8'h45, "R8 R5 December end");
        day_edge(8'h03, 8'h31, 8'h12, 8'h99, "R8 year 99 to 00");

        // write colliding with the one-second advance
        set_cal(8'h02, 8'h15, 8'h06, 8'h20);
        set_clock(8'h12, 8'h34, 8'h59);
        wr_tick(1, 8'h05);    expect_now("R11 minute write with carry");
        set_clock(8'h23, 8'h59, 8'h59);
        wr_tick(0, 8'h20);    expect_now("R11 seconds write with day advance");
        pulse(BDIV - 1);      expect_now("R11 R10 prescaler cleared by collision");
        pulse(1);             expect_now("R2 advance after collision");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule